// File: doc/BRIEF.md
# Vectored Interrupt Controller with Trigger Configuration

This block collects 64 interrupt requests and presents them to a processor as two outputs: a normal interrupt line and a fast interrupt line. The sources are held as two 32-bit banks. Source n lives in bank n/32 (address bit 2 picks the bank) at bit n%32. For each source, software chooses edge or level detection, the active polarity, and which of the two outputs it drives. It can also enable or disable the source, either by writing the whole enable word or by writing ones to a set alias or a clear alias.

Every incoming request passes through a two-flop synchronizer. A source in edge mode captures each active edge in a sticky latch, which stays set until software writes a one to the clear register. A source in level mode tracks its input directly. Software can also raise any source by writing a one to the software-trigger register. Read-only words return the raw pending bits, the pending bits masked by enable for each output, and the lowest-numbered pending interrupt routed to the normal line.

The bus is a plain synchronous port. Writes take effect at the clock edge where `bus_we` is high. Read data for the address presented in a cycle appears on `bus_rdata` after the next clock edge.

Top module: `vic_top`

## Requirements
- R1: After reset, every route, enable, type and polarity bit and both master bits are 0, both outputs are low, and the vector word at 0xD0 reads 0xFFFFFFFF.
- R2: Per-source words sit in pairs, with bank 0 at the base offset and bank 1 at base+4. The base offsets are: route 0x00 (1 = fast line), enable 0x10, enable-clear 0x20, enable-set 0x30, type 0x40 (1 = edge), polarity 0x50 (1 = falling/low active). Source n uses bit n%32 of the bank selected by n/32.
- R3: In edge mode (type bit 1), an active edge of the synchronized input sets a pending latch. The latch stays set after the input returns to idle, until a one is written to that bit of the clear word at 0xB0/0xB4. With polarity bit 1 the active edge is the falling one.
- R4: In level mode (type bit 0), a source is pending exactly while its synchronized input is at its active level: high for polarity 0, low for polarity 1.
- R5: A write to enable-set or enable-clear changes only the bits written as one. A direct write to the enable word replaces the whole word. Reading the enable word or either alias returns the current enable bits.
- R6: Writing a one to a bit of the software word at 0xC0/0xC4 makes that source pending. It stays pending until a one is written to the same bit of the clear word. The software word reads back its current bits.
- R7: Raw status at 0xA0/0xA4 shows all pending sources, whether enabled or not. 0x80/0x84 shows pending, enabled sources routed to the normal line, and 0x90/0x94 the same for the fast line. Master bits do not affect these words.
- R8: The master word at 0x64 holds two bits: bit 0 gates the normal line and bit 1 gates the fast line. Each output is registered and goes high one clock after a gated, enabled, pending source routed to it exists.
- R9: The word at 0xD0 returns the lowest source number that is pending, enabled and routed to the normal line, or 0xFFFFFFFF when there is none.
- R10: A level change on an input reaches the output on the third rising clock edge after it appears: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt requests, one per source |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Normal interrupt line |
| fiq_out | output | 1 | Fast interrupt line |

## Verification
The bound checker tests several rules on every cycle. Each output must follow the gated, masked pending set one clock later. The vector must name a pending IRQ-routed source with no lower-numbered one pending, or report none only when that set is empty. An edge latch must never drop unless its clear bit was written or its source left edge mode. The enables and outputs must be zero just after reset. Only the directed scenarios can show the behaviour seen through the bus: the alias semantics, which edge a given polarity detects, three-cycle input latency, software triggers persisting over many cycles, and the bank mapping of sources above 31.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 8;

  // Upper address nibble selects the register group.
  localparam logic [3:0] GRP_ROUTE  = 4'h0;
  localparam logic [3:0] GRP_EN     = 4'h1;
  localparam logic [3:0] GRP_ENCLR  = 4'h2;
  localparam logic [3:0] GRP_ENSET  = 4'h3;
  localparam logic [3:0] GRP_TYPE   = 4'h4;
  localparam logic [3:0] GRP_POL    = 4'h5;
  localparam logic [3:0] GRP_IRQST  = 4'h8;
  localparam logic [3:0] GRP_FIQST  = 4'h9;
  localparam logic [3:0] GRP_RAW    = 4'hA;
  localparam logic [3:0] GRP_CLR    = 4'hB;
  localparam logic [3:0] GRP_SOFT   = 4'hC;

  localparam logic [ADDR_W-1:0] ADDR_MASTER = 8'h64;
  localparam logic [ADDR_W-1:0] ADDR_VEC    = 8'hD0;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/vic_detect.sv
module vic_detect #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] type_i,   // 1 = edge
  input  logic [W-1:0] pol_i,    // 1 = falling / low
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hw_req_o,
  output logic [W-1:0] edge_q_o
);
  logic [W-1:0] prev_q, edge_q, act_now, act_prev;

  assign act_now  = sync_i ^ pol_i;
  assign act_prev = prev_q ^ pol_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= sync_i;
      edge_q <= type_i & ((edge_q & ~clr_i) | (act_now & ~act_prev));
    end
  end

  assign hw_req_o = (type_i & edge_q) | (~type_i & act_now);
  assign edge_q_o = edge_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq_out,
  output logic               fiq_out
);
  localparam int NBANK = NUM_SRC / DW;
  localparam int IDXW  = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] route_q, en_q, type_q, pol_q, soft_q;
  logic [1:0]         master_q;
  logic [NUM_SRC-1:0] bank_sel, wmask, clr_mask, soft_set;
  logic [NUM_SRC-1:0] synced, hw_req, edge_q, raw, irq_act, fiq_act;
  logic [3:0]         grp;
  logic               word_ok, wr_ok, vec_found;
  logic [IDXW-1:0]    vec_idx;
  logic [DW-1:0]      rd_word, vec_word;

  assign grp     = bus_addr[7:4];
  assign word_ok = ~bus_addr[3] & (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_we & word_ok;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_sel[b*DW +: DW] = {DW{int'(bus_addr[2]) == b}};
  end

  assign wmask    = {NBANK{bus_wdata}} & bank_sel;
  assign clr_mask = (wr_ok && grp == GRP_CLR)  ? wmask : '0;
  assign soft_set = (wr_ok && grp == GRP_SOFT) ? wmask : '0;

  vic_sync #(.W(NUM_SRC), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_i(irq_in), .sync_o(synced)
  );

  vic_detect #(.W(NUM_SRC)) u_detect (
    .clk(clk), .rst(rst), .sync_i(synced), .type_i(type_q), .pol_i(pol_q),
    .clr_i(clr_mask), .hw_req_o(hw_req), .edge_q_o(edge_q)
  );

  assign raw     = hw_req | soft_q;
  assign irq_act = raw & en_q & ~route_q;
  assign fiq_act = raw & en_q & route_q;

  vic_prio #(.W(NUM_SRC), .IW(IDXW)) u_prio (
    .req_i(irq_act), .found_o(vec_found), .idx_o(vec_idx)
  );

  assign vec_word = vec_found ? DW'(vec_idx) : '1;

  function automatic logic [DW-1:0] fold(input logic [NUM_SRC-1:0] v);
    logic [DW-1:0] acc = '0;
    for (int b = 0; b < NBANK; b++) acc |= v[b*DW +: DW];
    return acc;
  endfunction

  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_MASTER)      rd_word = DW'(master_q);
    else if (bus_addr == ADDR_VEC)    rd_word = vec_word;
    else if (word_ok) begin
      case (grp)
        GRP_ROUTE:                   rd_word = fold(route_q & bank_sel);
        GRP_EN, GRP_ENSET, GRP_ENCLR: rd_word = fold(en_q & bank_sel);
        GRP_TYPE:                    rd_word = fold(type_q & bank_sel);
        GRP_POL:                     rd_word = fold(pol_q & bank_sel);
        GRP_IRQST:                   rd_word = fold(irq_act & bank_sel);
        GRP_FIQST:                   rd_word = fold(fiq_act & bank_sel);
        GRP_RAW:                     rd_word = fold(raw & bank_sel);
        GRP_SOFT:                    rd_word = fold(soft_q & bank_sel);
        default:                     rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q   <= '0;
      en_q      <= '0;
      type_q    <= '0;
      pol_q     <= '0;
      soft_q    <= '0;
      master_q  <= '0;
      irq_out   <= 1'b0;
      fiq_out   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ok && grp == GRP_ROUTE) route_q <= (route_q & ~bank_sel) | wmask;
      if (wr_ok && grp == GRP_TYPE)  type_q  <= (type_q & ~bank_sel) | wmask;
      if (wr_ok && grp == GRP_POL)   pol_q   <= (pol_q & ~bank_sel) | wmask;
      if (wr_ok && grp == GRP_EN)         en_q <= (en_q & ~bank_sel) | wmask;
      else if (wr_ok && grp == GRP_ENSET) en_q <= en_q | wmask;
      else if (wr_ok && grp == GRP_ENCLR) en_q <= en_q & ~wmask;
      soft_q <= (soft_q | soft_set) & ~clr_mask;
      if (bus_we && bus_addr == ADDR_MASTER) master_q <= bus_wdata[1:0];
      irq_out   <= master_q[0] & (|irq_act);
      fiq_out   <= master_q[1] & (|fiq_act);
      bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_SRC = 64,
  parameter int IDXW    = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_out,
  input logic               fiq_out,
  input logic [1:0]         master_q,
  input logic [NUM_SRC-1:0] irq_act,
  input logic [NUM_SRC-1:0] fiq_act,
  input logic               vec_found,
  input logic [IDXW-1:0]    vec_idx,
  input logic [NUM_SRC-1:0] edge_q,
  input logic [NUM_SRC-1:0] type_q,
  input logic [NUM_SRC-1:0] clr_mask,
  input logic [NUM_SRC-1:0] en_q
);
  logic [NUM_SRC-1:0] below_idx;
  assign below_idx = (NUM_SRC'(1) << vec_idx) - NUM_SRC'(1);

  a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (master_q[0] && (|irq_act)) |=> irq_out);
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(master_q[0] && (|irq_act)) |=> !irq_out);
  a_r8_fiq_rise: assert property (@(posedge clk) disable iff (rst)
    (master_q[1] && (|fiq_act)) |=> fiq_out);
  a_r8_fiq_fall: assert property (@(posedge clk) disable iff (rst)
    !(master_q[1] && (|fiq_act)) |=> !fiq_out);
  a_r9_vec_hit: assert property (@(posedge clk) disable iff (rst)
    vec_found |-> irq_act[vec_idx]);
  a_r9_vec_lowest: assert property (@(posedge clk) disable iff (rst)
    vec_found |-> ((irq_act & below_idx) == '0));
  a_r9_vec_none: assert property (@(posedge clk) disable iff (rst)
    !vec_found |-> (irq_act == '0));
  a_r3_edge_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(edge_q & type_q & ~clr_mask) & ~edge_q) == '0));
  a_r1_reset_state: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (en_q == '0 && !irq_out && !fiq_out));
endmodule

bind vic_top vic_checker #(.NUM_SRC(NUM_SRC), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .fiq_out(fiq_out),
  .master_q(master_q), .irq_act(irq_act), .fiq_act(fiq_act),
  .vec_found(vec_found), .vec_idx(vec_idx), .edge_q(edge_q),
  .type_q(type_q), .clr_mask(clr_mask), .en_q(en_q)
);

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vic_top dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_in = '0; bus_we = 1'b0;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h00, d); chk("R1 route", d, 32'h0);
    rd(8'h10, d); chk("R1 enable", d, 32'h0);
    rd(8'h44, d); chk("R1 type", d, 32'h0);
    rd(8'h54, d); chk("R1 polarity", d, 32'h0);
    rd(8'h64, d); chk("R1 master", d, 32'h0);
    rd(8'hD0, d); chk("R1 vector", d, 32'hFFFF_FFFF);
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    chk("R1 fiq_out", 32'(fiq_out), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    wr(8'h64, 32'h3);
    wr(8'h30, 32'h8);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R10 not yet after two edges", 32'(irq_out), 32'h0);
    @(negedge clk); chk("R10 irq_out on third edge", 32'(irq_out), 32'h1);
    rd(8'hD0, d); chk("R9 vector level src3", d, 32'd3);
    rd(8'h80, d); chk("R7 irq status", d, 32'h8);
    irq_in[3] = 1'b0;
    cyc(5);
    chk("R4 level drops with input", 32'(irq_out), 32'h0);
    // R4 R2 active-low level on source 40 (bank 1 bit 8)
    wr(8'h54, 32'h100);
    wr(8'h34, 32'h100);
    cyc(3);
    rd(8'hA4, d); chk("R4 active-low raw", d, 32'h100);
    rd(8'hD0, d); chk("R2 vector src40", d, 32'd40);
    irq_in[40] = 1'b1;
    cyc(5);
    rd(8'hA4, d); chk("R4 inactive high", d, 32'h0);
    chk("R4 irq_out low", 32'(irq_out), 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    do_reset();
    wr(8'h64, 32'h1);
    wr(8'h40, 32'h60);
    wr(8'h50, 32'h40);
    wr(8'h30, 32'h60);
    cyc(4);
    rd(8'hA0, d); chk("R3 no edge from polarity write", d, 32'h0);
    irq_in[5] = 1'b1; cyc(2); irq_in[5] = 1'b0;
    cyc(6);
    rd(8'hA0, d); chk("R3 rising edge latched", d, 32'h20);
    chk("R3 irq_out held", 32'(irq_out), 32'h1);
    wr(8'hB0, 32'h20);
    rd(8'hA0, d); chk("R3 latch cleared", d, 32'h0);
    chk("R3 irq_out after clear", 32'(irq_out), 32'h0);
    irq_in[6] = 1'b1; cyc(4);
    rd(8'hA0, d); chk("R3 rising ignored when falling active", d, 32'h0);
    irq_in[6] = 1'b0; cyc(5);
    rd(8'hA0, d); chk("R3 falling edge latched", d, 32'h40);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    wr(8'h10, 32'hF0);
    wr(8'h30, 32'hF00);
    rd(8'h10, d); chk("R5 set alias", d, 32'hFF0);
    wr(8'h20, 32'h30);
    rd(8'h10, d); chk("R5 clear alias", d, 32'hFC0);
    rd(8'h30, d); chk("R5 alias readback", d, 32'hFC0);
    rd(8'h14, d); chk("R2 other bank untouched", d, 32'h0);
    wr(8'h10, 32'h1);
    rd(8'h10, d); chk("R5 direct write", d, 32'h1);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    do_reset();
    wr(8'h64, 32'h3);
    wr(8'h34, 32'h1);
    wr(8'hC4, 32'h1);
    cyc(10);
    chk("R6 soft irq_out", 32'(irq_out), 32'h1);
    rd(8'hC4, d); chk("R6 soft readback", d, 32'h1);
    rd(8'hD0, d); chk("R6 vector src32", d, 32'd32);
    wr(8'hB4, 32'h1);
    rd(8'hA4, d); chk("R6 soft cleared", d, 32'h0);
    rd(8'hD0, d); chk("R9 vector none", d, 32'hFFFF_FFFF);
    chk("R6 irq_out cleared", 32'(irq_out), 32'h0);
  endtask

  task automatic t_fiq();
    logic [31:0] d;
    do_reset();
    wr(8'h64, 32'h2);
    wr(8'h00, 32'h4);
    wr(8'h30, 32'h4);
    wr(8'hC0, 32'h4);
    cyc(2);
    chk("R8 fiq_out", 32'(fiq_out), 32'h1);
    chk("R8 irq_out idle", 32'(irq_out), 32'h0);
    rd(8'h90, d); chk("R7 fiq status", d, 32'h4);
    rd(8'h80, d); chk("R7 irq status empty", d, 32'h0);
    rd(8'hD0, d); chk("R9 fiq not vectored", d, 32'hFFFF_FFFF);
    wr(8'h64, 32'h1);
    cyc(2);
    chk("R8 fiq gated by master", 32'(fiq_out), 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(8'h64, 32'h1);
    wr(8'hC0, 32'h210);
    wr(8'h30, 32'h10);
    rd(8'hA0, d); chk("R7 raw includes disabled", d, 32'h210);
    rd(8'h80, d); chk("R7 masked irq status", d, 32'h10);
    rd(8'hD0, d); chk("R9 vector src4", d, 32'd4);
    wr(8'h30, 32'h200);
    rd(8'hD0, d); chk("R9 lowest wins", d, 32'd4);
    wr(8'hB0, 32'h10);
    rd(8'hD0, d); chk("R9 next after clear", d, 32'd9);
    wr(8'h64, 32'h0);
    cyc(2);
    chk("R8 irq gated by master", 32'(irq_out), 32'h0);
    rd(8'h80, d); chk("R7 status ignores master", d, 32'h200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_enable();
    t_soft();
    t_fiq();
    t_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule